// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The host offers one request at a time over a valid/ready handshake. Each request is a single byte read or a single byte write. The controller turns each request into the chip-enable, output-enable and write-enable sequence the memory needs. Every phase of that sequence lasts a whole number of clock cycles, and each phase length is computed from the clock period and the memory's timing limits, rounded up.

The memory has two chip enables with opposite polarity: the first is active low and the second is active high. The controller always moves them together. The data bus is split into three signals: an output value, a driver enable and an input value. The pad ring combines them into the bidirectional bus. Writes keep output enable high throughout. The controller turns on its own drivers only after the memory's outputs have had time to float. A read captures the bus at the edge that closes the access interval. After every read, a turnaround gap follows in which neither side drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and directly after it, the chip-select low input is high, the chip-select high input is low, write enable and output enable are high, the data driver enable is low, ready is high and read-valid is low.
- R2: A write holds the chip-select low input low, the chip-select high input high and write enable low together, with output enable high during the whole write.
- R3: Write enable stays low for at least WP_C cycles. WP_C is the largest of the pulse width, the address-valid-to-end time, and the sum of the float time plus the data setup time, each rounded up; this gives 12 cycles at defaults. The address stays stable while the chip is selected.
- R4: The write-data drivers switch on only after write enable has been low for more than HZW_C cycles (5 at defaults). The data is stable for at least DS_C cycles (6) before write enable rises, and is still driven in the cycle in which write enable is high again.
- R5: The chip stays selected for at least WR_C cycles per write (14 at defaults).
- R6: A read holds both chip selects active, output enable low and write enable high for RD_C cycles (14). The data bus is captured at the last edge of that interval. Read-valid then pulses high for exactly one cycle, carrying the captured byte.
- R7: After a read, the chip is deselected and output enable is high for exactly TA_C cycles (5) before ready returns. The controller does not drive the bus during these cycles.
- R8: Ready is high only when the controller is idle. A request is accepted only on an edge where both valid and ready are high. A request held while ready is low has no effect.
- R9: The two chip selects are always asserted and released together.
- R10: The data driver enable is never high while output enable is low, or within the float time after the memory last drove the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data value driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 8 | Data bus as seen from the memory |

## Verification
The bench stimulates the controller through four kinds of traffic, each aimed at a different fault:
- A walking one across all seventeen address bits, followed by reads of every written location. This separates address lines that are swapped or stuck.
- All-zero, all-one and alternating data patterns. These expose data-path bit errors.
- Back-to-back write-then-read and read-then-write pairs at the same address. These exercise the turnaround and the write that must land before the read.
- A request held high while the controller is busy, followed by a read of the address it named. This shows whether a request was taken when it should have been ignored.

The bench's memory model returns a garbage byte until the full access time has passed. A capture taken one edge early therefore shows up as a data mismatch.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 5,
  parameter int T_WC    = 70,
  parameter int T_WP    = 55,
  parameter int T_AW    = 60,
  parameter int T_DS    = 30,
  parameter int T_RC    = 70,
  parameter int T_AA    = 70,
  parameter int T_OE    = 35,
  parameter int T_HZ_WE = 25,
  parameter int T_HZ_OE = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int cyc(input int t_ns);
    return (t_ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HZW_C = max2(1, cyc(T_HZ_WE));
  localparam int DS_C  = max2(1, cyc(T_DS));
  localparam int WP_C  = max2(max2(cyc(T_WP), cyc(T_AW)), HZW_C + DS_C);
  localparam int WR_C  = max2(cyc(T_WC), WP_C + 1);
  localparam int RD_C  = max2(2, max2(max2(cyc(T_RC), cyc(T_AA)), cyc(T_OE)));
  localparam int TA_C  = max2(1, cyc(T_HZ_OE));
  localparam int CNT_MAX = max2(max2(WR_C, RD_C), TA_C);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] HZW_L  = CNT_W'(HZW_C);
  localparam logic [CNT_W-1:0] WP_L   = CNT_W'(WP_C);
  localparam logic [CNT_W-1:0] WR_END = CNT_W'(WR_C - 1);
  localparam logic [CNT_W-1:0] RD_END = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] TA_END = CNT_W'(TA_C - 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_TURN} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx    = cnt + 1'b1;
  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cnt       <= '0;
            mem_addr  <= req_addr;
            mem_dq_o  <= req_wdata;
            mem_ce1_n <= 1'b0;
            mem_ce2   <= 1'b1;
            if (req_write) begin
              state    <= S_WR;
              mem_we_n <= 1'b0;
              mem_oe_n <= 1'b1;
            end else begin
              state    <= S_RD;
              mem_we_n <= 1'b1;
              mem_oe_n <= 1'b0;
            end
          end
        end
        S_WR: begin
          cnt       <= cnt_nx;
          mem_we_n  <= (cnt_nx >= WP_L);
          mem_dq_oe <= (cnt_nx >= HZW_L) && (cnt_nx <= WP_L);
          if (cnt == WR_END) begin
            state     <= S_IDLE;
            cnt       <= '0;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
        end
        S_RD: begin
          cnt <= cnt_nx;
          if (cnt == RD_END) begin
            rd_data   <= mem_dq_i;
            rd_valid  <= 1'b1;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            state     <= S_TURN;
            cnt       <= '0;
          end
        end
        default: begin
          cnt <= cnt_nx;
          if (cnt == TA_END) begin
            state <= S_IDLE;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  a_r9_enables_paired: assert property (@(posedge clk) disable iff (rst)
    mem_ce1_n == !mem_ce2);

  a_r2_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce1_n));

  a_r10_drive_excl: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r4_drive_selected: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_ce1_n);

  a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r6_no_we_in_read: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  a_r8_ready_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int HZ = 5, WP = 12, DS = 6, WR = 14, RD = 14, TA = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid;
  logic [7:0] rd_data;
  logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #2.5 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] shadow [int];
  logic [7:0] memory [int];
  logic [7:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model and timing monitor
  int we_run = 0, dstab = 0, sel_run = 0, acc = 0, gap = 100, tcnt = 0;
  bit prev_ovl = 0, prev_sel = 0, sel_wr = 0, prev_rd = 0, in_turn = 0, prev_dqoe = 0, prev_rdv = 0;
  logic [7:0] prev_dq = '0;

  always @(negedge clk) begin
    bit sel, ovl, rdm;
    if (!rst) begin
      sel = !mem_ce1_n && mem_ce2;
      ovl = sel && !mem_we_n;
      rdm = sel && mem_we_n && !mem_oe_n;
      if (ovl) begin
        we_run++;
        if (mem_dq_oe && prev_dqoe && mem_dq_o == prev_dq) dstab++;
        else dstab = mem_dq_oe ? 1 : 0;
        chk(!(mem_dq_oe && we_run <= HZ), "R4 driver early", we_run, HZ + 1);
        chk(mem_oe_n, "R2 oe high in write", mem_oe_n, 1);
      end else if (prev_ovl) begin
        chk(we_run >= WP, "R3 we pulse", we_run, WP);
        chk(dstab >= DS, "R4 data setup", dstab, DS);
        chk(mem_dq_oe, "R4 data hold", mem_dq_oe, 1);
        memory[int'(mem_addr)] = mem_dq_o;
        we_run = 0;
      end
      if (sel) begin
        sel_run++;
        if (ovl) sel_wr = 1;
      end else if (prev_sel) begin
        if (sel_wr) chk(sel_run >= WR, "R5 write cycle", sel_run, WR);
        sel_run = 0; sel_wr = 0;
      end
      chk(!(mem_dq_oe && (rdm || gap < HZ)), "R10 bus contention", gap, HZ);
      if (rdm) gap = 0; else if (gap < 100) gap++;
      if (prev_rd && !rdm) begin in_turn = 1; tcnt = 0; end
      if (in_turn) begin
        if (!req_ready) begin
          tcnt++;
          chk(!mem_dq_oe && mem_ce1_n, "R7 quiet turnaround", {mem_dq_oe, mem_ce1_n}, 2'b01);
        end else begin
          chk(tcnt == TA, "R7 turnaround length", tcnt, TA);
          in_turn = 0;
        end
      end
      if (rd_valid) begin
        chk(!prev_rdv, "R6 single pulse", prev_rdv, 0);
        chk(!req_ready, "R8 busy in turnaround", req_ready, 0);
        if (expq.size() == 0) chk(0, "R6 unexpected read", rd_data, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(rd_data == e, "R6 read data", rd_data, e);
        end
      end
      acc = rdm ? acc + 1 : 0;
      mem_dq_i = (rdm && acc >= RD) ?
                 (memory.exists(int'(mem_addr)) ? memory[int'(mem_addr)] : 8'h00) : 8'hEE;
      prev_ovl = ovl; prev_sel = sel; prev_rd = rdm; prev_dqoe = mem_dq_oe;
      prev_dq = mem_dq_o; prev_rdv = rd_valid;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid} == 6'b101100,
        "R1 reset outputs", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 6'b101100);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && !mem_dq_oe, "R1 after reset",
        {req_ready, mem_ce1_n, mem_ce2, mem_dq_oe}, 4'b1100);

    for (int i = 0; i < 17; i++) issue(1, 17'(1) << i, 8'(i * 13 + 7));
    issue(1, 17'h00000, 8'h00);
    issue(1, 17'h1FFFF, 8'hFF);
    for (int i = 0; i < 17; i++) issue(0, 17'(1) << i, 8'h0);
    issue(0, 17'h00000, 8'h0);
    issue(0, 17'h1FFFF, 8'h0);
    // data patterns, write-then-read and read-then-write
    issue(1, 17'h0AAAA, 8'hAA); issue(0, 17'h0AAAA, 8'h0);
    issue(1, 17'h15555, 8'h55); issue(0, 17'h15555, 8'h0);
    issue(0, 17'h0AAAA, 8'h0);  issue(1, 17'h0AAAA, 8'h3C); issue(0, 17'h0AAAA, 8'h0);
    issue(1, 17'h00100, 8'h11); issue(1, 17'h00100, 8'h22); issue(0, 17'h00100, 8'h0);

    // R8: request held while busy must be ignored
    issue(1, 17'h00200, 8'h5A);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'hC3;
    repeat (5) begin
      @(negedge clk);
      chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    issue(0, 17'h00300, 8'h0);
    issue(0, 17'h00200, 8'h0);

    repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R6 all reads returned", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule